// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block owns the two threshold registers that a FIFO's almost-empty and almost-full flags compare against: the empty offset and the full offset. While master reset is held, it samples the flag-select pair and the load pin. These three bits pick one of eight default thresholds, which both registers take. The load pin also decides, for the rest of the session, whether software programs the thresholds one bit at a time or a whole word at a time. The dual-use mode pin is captured during reset as the first-word-fall-through selection and serves as the serial data bit afterwards. A parity-layout option is captured at the same time and affects only how parallel words map onto the offsets.

After reset, the offsets can be written or read back only while the load pin is held low. In parallel mode the bus words go alternately to the empty offset and the full offset. In serial mode the mode pin is shifted in, empty offset first. A partial reset restarts the write and read sequences but keeps every programmed value and every reset-time choice. The FIFO storage and the flag comparators sit outside this block.

Top module: `flag_offset_loader`

## Requirements
- R1: During master reset (rst_n low at a rising clk edge), both offsets load the default (8 << idx) - 1, where idx = {load_n, fsel[1], fsel[0]}, and dout clears to zero.
- R2: The value of load_n sampled at master reset selects the programming method for the session: 0 selects parallel, 1 selects serial.
- R3: fwft_mode takes the value of si_fwft sampled at master reset and does not follow si_fwft afterwards.
- R4: In parallel mode, each clock with wr_en high and load_n low writes a bus word. Writes go alternately to the empty offset and the full offset, starting with the empty offset. Without the parity layout, the offset is din[16:0].
- R5: With the parity layout (ilv_sel high at master reset), a parallel write takes the offset as {din[17:9], din[7:0]}, so din[8] has no effect.
- R6: In serial mode, each write clock shifts si_fwft into one offset bit, least significant bit first. The 17 empty-offset bits come first, then the 17 full-offset bits. After the last full-offset bit the sequence wraps to empty bit 0.
- R7: A clock with load_n high changes neither offset, even when wr_en is high.
- R8: A clock with rd_en high and load_n low places an offset on dout one clock later: the empty offset first, then the full offset, alternating. The layout is the same as for writes, and unused bits are zero. At other times dout holds its value.
- R9: A partial reset (prst_n low at a rising edge) keeps both offsets, the method, the parity layout and fwft_mode. It clears dout and restarts the write pointer, the read pointer and the serial bit position at empty offset bit 0.
- R10: In serial mode din has no effect on the offsets. In parallel mode si_fwft has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous active-low master reset |
| prst_n | input | 1 | Synchronous active-low partial reset |
| fsel | input | 2 | Default-offset select, sampled at master reset |
| load_n | input | 1 | Default select and method choice at reset; active-low access enable after reset |
| si_fwft | input | 1 | First-word-fall-through select at reset; serial data bit after reset |
| ilv_sel | input | 1 | Parity layout select, sampled at master reset |
| wr_en | input | 1 | Write enable for offset programming |
| rd_en | input | 1 | Read enable for offset readback |
| din | input | 18 | Parallel programming word |
| dout | output | 18 | Readback word |
| empty_ofs | output | 17 | Almost-empty threshold |
| full_ofs | output | 17 | Almost-full threshold |
| fwft_mode | output | 1 | First-word-fall-through mode captured at reset |

## Verification
The hardest state to reach is a partial reset that arrives in the middle of a sequence, when the serial bit position or the parallel pointer sits somewhere other than its start. The offsets then hold values that hide the pointer. The stimulus shifts in a full 34-bit round plus one wrapping bit, or makes a single parallel write, and then pulses partial reset. It follows with a full-width load whose final values show whether the pointer restarted at empty bit 0. The parity layout test writes words that have only the parity bit set, so a decode that is off by one position shows up at once.

// File: rtl/ofl_pkg.sv
`timescale 1ns/1ps
// Package for the flag offset loader: reset-time configuration record and
// the default-threshold rule shared by the register module.
package ofl_pkg;

    // Choices captured while master reset is held
    typedef struct packed {
        logic serial;   // 1: bit-serial programming, 0: word programming
        logic ilv;      // parity layout for word programming
        logic fwft;     // first-word-fall-through selection
    } ofl_cfg_t;

    // Default threshold for a 3-bit reset select: 7, 15, 31 ... 1023
    function automatic logic [31:0] ofl_default(input logic [2:0] idx);
        return (32'd8 << idx) - 32'd1;
    endfunction

endpackage

// File: rtl/ofl_cfg_latch.sv
`timescale 1ns/1ps
// Captures the reset-time configuration pins while master reset is low.
// Assumes the pins are stable during master reset; afterwards they are ignored.
module ofl_cfg_latch
    import ofl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_n,
    input  logic     si_fwft,
    input  logic     ilv_sel,
    output ofl_cfg_t cfg
);

    // Sample configuration only during master reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.serial <= load_n;
            cfg.ilv    <= ilv_sel;
            cfg.fwft   <= si_fwft;
        end
    end

    // R3
    fwft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg.fwft));

endmodule

// File: rtl/ofl_regs.sv
`timescale 1ns/1ps
// Holds the empty and full offsets. Loads a default at master reset and takes
// word writes (alternating pointer) or bit-serial writes afterwards.
// Assumes OFFS_W <= DATA_W and PAR_POS < DATA_W.
module ofl_regs
    import ofl_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int OFFS_W  = 17,
    parameter int PAR_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic [1:0]        fsel,
    input  logic              load_n,
    input  logic              si_fwft,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    input  logic              serial,
    input  logic              ilv,
    output logic [OFFS_W-1:0] empty_ofs,
    output logic [OFFS_W-1:0] full_ofs
);

    localparam int IDX_W = (OFFS_W > 1) ? $clog2(OFFS_W) : 1;
    localparam logic [IDX_W-1:0] LANE_LAST = IDX_W'(OFFS_W - 1);

    logic [OFFS_W-1:0] par_pl, par_ilv, par_val;
    logic [IDX_W-1:0]  lane;       // serial bit position inside current offset
    logic              lane_full;  // serial: 1 while filling the full offset
    logic              wr_full;    // parallel: next word goes to full offset
    logic              wr_go;

    // Word decode for both layouts; the parity layout skips bit PAR_POS
    for (genvar g = 0; g < OFFS_W; g++) begin : g_dec
        localparam int SRC = (g >= PAR_POS) ? g + 1 : g;
        assign par_pl[g] = din[g];
        if (SRC < DATA_W) begin : g_in
            assign par_ilv[g] = din[SRC];
        end else begin : g_out
            assign par_ilv[g] = 1'b0;
        end
    end

    // Layout chosen at reset picks the decoded word
    always_comb begin
        par_val = ilv ? par_ilv : par_pl;
        wr_go   = wr_en && !load_n;
    end

    // Offset registers: default load, then serial or word writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_ofs <= OFFS_W'(ofl_default({load_n, fsel}));
            full_ofs  <= OFFS_W'(ofl_default({load_n, fsel}));
        end else if (prst_n && wr_go) begin
            if (serial) begin
                if (lane_full) full_ofs[lane]  <= si_fwft;
                else           empty_ofs[lane] <= si_fwft;
            end else begin
                if (wr_full) full_ofs  <= par_val;
                else         empty_ofs <= par_val;
            end
        end
    end

    // Write pointers: restart on either reset, advance per accepted write
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            lane      <= '0;
            lane_full <= 1'b0;
            wr_full   <= 1'b0;
        end else if (wr_go) begin
            if (serial) begin
                if (lane == LANE_LAST) begin
                    lane      <= '0;
                    lane_full <= !lane_full;
                end else begin
                    lane <= lane + 1'b1;
                end
            end else begin
                wr_full <= !wr_full;
            end
        end
    end

    // R1
    default_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (empty_ofs == OFFS_W'(ofl_default($past({load_n, fsel})))
                           && full_ofs == empty_ofs));

    // R7
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R9
    prst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R6
    serial_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serial |=> ($countones({empty_ofs, full_ofs} ^ $past({empty_ofs, full_ofs})) <= 1));

endmodule

// File: rtl/ofl_readback.sv
`timescale 1ns/1ps
// Returns the offsets on the data output, empty first then full, in the same
// word layout used for writing. One clock of latency from the read enable.
module ofl_readback #(
    parameter int DATA_W  = 18,
    parameter int OFFS_W  = 17,
    parameter int PAR_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              load_n,
    input  logic              rd_en,
    input  logic              ilv,
    input  logic [OFFS_W-1:0] empty_ofs,
    input  logic [OFFS_W-1:0] full_ofs,
    output logic [DATA_W-1:0] dout
);

    logic              rd_full;
    logic              rd_go;
    logic [OFFS_W-1:0] sel_val;
    logic [DATA_W-1:0] enc_pl, enc_ilv;

    // Pick the offset the read pointer addresses
    always_comb begin
        sel_val = rd_full ? full_ofs : empty_ofs;
        rd_go   = rd_en && !load_n;
    end

    // Word encode for both layouts; parity position reads back as zero
    for (genvar d = 0; d < DATA_W; d++) begin : g_enc
        localparam int SRC = (d < PAR_POS) ? d : d - 1;
        if (d < OFFS_W) begin : g_pl
            assign enc_pl[d] = sel_val[d];
        end else begin : g_plz
            assign enc_pl[d] = 1'b0;
        end
        if (d != PAR_POS && SRC < OFFS_W) begin : g_il
            assign enc_ilv[d] = sel_val[SRC];
        end else begin : g_ilz
            assign enc_ilv[d] = 1'b0;
        end
    end

    // Output register and read pointer
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            dout    <= '0;
            rd_full <= 1'b0;
        end else if (rd_go) begin
            dout    <= ilv ? enc_ilv : enc_pl;
            rd_full <= !rd_full;
        end
    end

    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !rd_go) |=> $stable(dout));

    // R9
    prst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> (dout == '0));

endmodule

// File: rtl/flag_offset_loader.sv
`timescale 1ns/1ps
// Top of the programmable flag offset loader: configuration capture, offset
// registers with serial or word programming, and registered readback.
// Assumes a single clock for writes and reads; resets are synchronous.
module flag_offset_loader
    import ofl_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int OFFS_W  = DATA_W - 1,
    parameter int PAR_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic [1:0]        fsel,
    input  logic              load_n,
    input  logic              si_fwft,
    input  logic              ilv_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [OFFS_W-1:0] empty_ofs,
    output logic [OFFS_W-1:0] full_ofs,
    output logic              fwft_mode
);

    ofl_cfg_t cfg;

    ofl_cfg_latch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .si_fwft (si_fwft),
        .ilv_sel (ilv_sel),
        .cfg     (cfg)
    );

    ofl_regs #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .PAR_POS(PAR_POS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .prst_n    (prst_n),
        .fsel      (fsel),
        .load_n    (load_n),
        .si_fwft   (si_fwft),
        .wr_en     (wr_en),
        .din       (din),
        .serial    (cfg.serial),
        .ilv       (cfg.ilv),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    ofl_readback #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .PAR_POS(PAR_POS)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prst_n    (prst_n),
        .load_n    (load_n),
        .rd_en     (rd_en),
        .ilv       (cfg.ilv),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .dout      (dout)
    );

    // Captured mode pin drives the mode output
    assign fwft_mode = cfg.fwft;

endmodule

// File: tb/flag_offset_loader_test.sv
`timescale 1ns/1ps
// Bench for flag_offset_loader: a vector table for parallel writes, then
// directed tests for defaults, serial shifting, parity layout and partial reset.
module flag_offset_loader_test;

    localparam int DW = 18;
    localparam int OW = 17;

    logic          clk = 1'b0;
    logic          rst_n, prst_n, load_n, si_fwft, ilv_sel, wr_en, rd_en;
    logic [1:0]    fsel;
    logic [DW-1:0] din, dout;
    logic [OW-1:0] empty_ofs, full_ofs;
    logic          fwft_mode;
    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;

    flag_offset_loader uut (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .fsel(fsel), .load_n(load_n),
        .si_fwft(si_fwft), .ilv_sel(ilv_sel), .wr_en(wr_en), .rd_en(rd_en),
        .din(din), .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .fwft_mode(fwft_mode)
    );

    always #2.5 clk = ~clk;

    // Parallel write vectors, non-parity layout; even entries hit empty offset
    localparam logic [DW-1:0] PVEC [0:5] = '{
        18'h3FFFF, 18'h00000, 18'h15555, 18'h2AAAA, 18'h00100, 18'h20001
    };

    function automatic logic [OW-1:0] dec(input logic [DW-1:0] d, input logic il);
        return il ? {d[17:9], d[7:0]} : d[16:0];
    endfunction

    function automatic logic [DW-1:0] enc(input logic [OW-1:0] v, input logic il);
        return il ? {v[16:8], 1'b0, v[7:0]} : {1'b0, v};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mreset(input logic ld, input logic [1:0] fs, input logic si, input logic il);
        rst_n = 1'b0; load_n = ld; fsel = fs; si_fwft = si; ilv_sel = il;
        wr_en = 1'b0; rd_en = 1'b0;
        tick();
        rst_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic pwrite(input logic [DW-1:0] d, input logic si);
        load_n = 1'b0; wr_en = 1'b1; din = d; si_fwft = si;
        tick();
        load_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic sbit(input logic b, input logic [DW-1:0] junk);
        load_n = 1'b0; wr_en = 1'b1; si_fwft = b; din = junk;
        tick();
        load_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic pread();
        load_n = 1'b0; rd_en = 1'b1;
        tick();
        load_n = 1'b1; rd_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [OW-1:0] exp_e, exp_f;
        logic [OW-1:0] se, sf;
        rst_n = 1'b0; prst_n = 1'b1; load_n = 1'b1; fsel = 2'b00; si_fwft = 1'b0;
        ilv_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; din = '0;
        @(negedge clk);

        // R1: every default select
        for (int i = 0; i < 8; i++) begin
            mreset(i[2], i[1:0], 1'b0, 1'b0);
            chk("R1 empty default", 32'(empty_ofs), (32'd8 << i) - 32'd1);
            chk("R1 full default", 32'(full_ofs), (32'd8 << i) - 32'd1);
        end
        chk("R1 dout cleared", 32'(dout), 32'd0);

        // Parallel session, fwft on
        mreset(1'b0, 2'b11, 1'b1, 1'b0);
        chk("R3 fwft captured", 32'(fwft_mode), 32'd1);
        si_fwft = 1'b0; tick(); tick();
        chk("R3 fwft ignores pin", 32'(fwft_mode), 32'd1);

        // R4 / R2 / R10: vector walk, si toggling must not matter
        exp_e = 17'd63; exp_f = 17'd63;
        for (int i = 0; i < 6; i++) begin
            pwrite(PVEC[i], i[0]);
            if (i % 2 == 0) exp_e = dec(PVEC[i], 1'b0);
            else            exp_f = dec(PVEC[i], 1'b0);
            chk("R4 R2 R10 empty after write", 32'(empty_ofs), 32'(exp_e));
            chk("R4 full after write", 32'(full_ofs), 32'(exp_f));
        end

        // R7: write with load_n high ignored
        load_n = 1'b1; wr_en = 1'b1; din = 18'h1234F; tick(); wr_en = 1'b0;
        chk("R7 empty unchanged", 32'(empty_ofs), 32'(exp_e));
        chk("R7 full unchanged", 32'(full_ofs), 32'(exp_f));

        // R8: readback order and hold
        pread(); chk("R8 read empty", 32'(dout), 32'(enc(exp_e, 1'b0)));
        pread(); chk("R8 read full", 32'(dout), 32'(enc(exp_f, 1'b0)));
        pread(); chk("R8 read wraps", 32'(dout), 32'(enc(exp_e, 1'b0)));
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R8 read ignored with load_n high", 32'(dout), 32'(enc(exp_e, 1'b0)));

        // R9: partial reset mid-pair in parallel mode
        pwrite(18'h00ABC, 1'b0); exp_e = 17'h00ABC;
        prst_n = 1'b0; tick(); prst_n = 1'b1;
        chk("R9 empty kept", 32'(empty_ofs), 32'(exp_e));
        chk("R9 full kept", 32'(full_ofs), 32'(exp_f));
        chk("R9 dout cleared", 32'(dout), 32'd0);
        chk("R9 fwft kept", 32'(fwft_mode), 32'd1);
        pwrite(18'h00777, 1'b1);
        chk("R9 write pointer restarted", 32'(empty_ofs), 32'h777);
        chk("R9 full untouched", 32'(full_ofs), 32'(exp_f));

        // Serial session: idx 4 -> 127
        mreset(1'b1, 2'b00, 1'b0, 1'b0);
        chk("R3 fwft off", 32'(fwft_mode), 32'd0);
        sbit(1'b0, 18'h3FFFF);
        chk("R2 R10 serial bit, bus ignored", 32'(empty_ofs), 32'd126);
        se = 17'h1A5C3; sf = 17'h01234;
        for (int b = 1; b < OW; b++) sbit(se[b], 18'h3FFFF);
        chk("R6 empty shifted", 32'(empty_ofs & 17'h1FFFE), 32'(se & 17'h1FFFE));
        chk("R6 full untouched", 32'(full_ofs), 32'd127);
        for (int b = 0; b < OW; b++) sbit(sf[b], 18'h15555);
        chk("R6 full shifted", 32'(full_ofs), 32'(sf));
        sbit(1'b1, 18'h0);
        chk("R6 wrap to empty bit0", 32'(empty_ofs), 32'(se & 17'h1FFFE | 17'h1));
        pread();
        chk("R8 serial readback", 32'(dout), 32'(enc(se | 17'h1, 1'b0)));
        sbit(1'b0, 18'h0); sbit(1'b0, 18'h0);
        prst_n = 1'b0; tick(); prst_n = 1'b1;
        for (int b = 0; b < OW; b++) sbit(1'b1, 18'h0);
        chk("R9 serial position restarted", 32'(empty_ofs), 32'h1FFFF);
        chk("R9 serial full kept", 32'(full_ofs), 32'(sf));

        // Parity layout session: idx 1 -> 15
        mreset(1'b0, 2'b01, 1'b0, 1'b1);
        chk("R1 parity default", 32'(empty_ofs), 32'd15);
        pwrite(18'h2FE55, 1'b0);
        chk("R5 parity decode", 32'(empty_ofs), 32'(dec(18'h2FE55, 1'b1)));
        pwrite(18'h00100, 1'b0);
        chk("R5 parity bit ignored", 32'(full_ofs), 32'd0);
        pread();
        chk("R5 R8 parity readback", 32'(dout), 32'(enc(dec(18'h2FE55, 1'b1), 1'b1)));

        summary();
    end

endmodule